// File: doc/BRIEF.md
# Strobe-Handshake Fall-Through FIFO

This block is a first-in first-out buffer of 64 words of 4 bits. Writers and readers do not use enables. Instead they raise and lower two strobes. A high level on the shift-in strobe captures the word on the data input. The falling edge of the shift-out strobe removes the word shown at the output. Stored words move forward to the output register on their own, so the oldest word is always on the data output without any read request.

Two flags carry the handshake. The input-ready flag says a word can be accepted. It drops once the current strobe has been taken, and it stays low while the buffer is full. The output-ready flag says the output word is valid. It drops once a shift-out strobe has been seen, and it stays low while the buffer is empty. Both strobes are treated as asynchronous levels. Each is brought into the clock domain through two flip-flops before it is used. An active-low reset clears the contents and the flags.

Top module: `strobe_fifo`

## Requirements
- R1: The buffer holds up to DEPTH (64) words of WIDTH (4) bits. Words appear on the data output unchanged and in the order they were written.
- R2: A word is captured once per high phase of the shift-in strobe, using the data present a few cycles after the strobe rises. A shift-in strobe that starts and ends while the buffer is full is ignored.
- R3: A falling edge of the shift-out strobe removes the head word. A shift-out strobe applied while the buffer is empty is ignored.
- R4: The input-ready flag is low while the buffer is full, low after a word has been taken until shift-in returns low, and high otherwise.
- R5: The output-ready flag is high only while a valid word is on the output and no shift-out strobe is pending. It is low while the buffer is empty.
- R6: When shift-out is already held high and a word enters an empty buffer, output-ready rises for exactly one clock cycle. The word is then removed when shift-out falls.
- R7: When the buffer is full and shift-in is held high, a shift-out pulse frees a slot. Input-ready then rises for exactly one clock cycle, and the waiting input word is captured.
- R8: After the last word is removed, the data output keeps showing that word until a new word falls through or reset is asserted.
- R9: While reset is low, the buffer is empty, the data output is all zeros, input-ready is high and output-ready is low. If shift-in is high when reset is released, the input word is captured. If shift-in falls before the release, nothing is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shift_in | input | 1 | Shift-in strobe, asynchronous level |
| shift_out | input | 1 | Shift-out strobe, asynchronous level |
| din | input | WIDTH | Input word |
| dout | output | WIDTH | Head word, held after the buffer empties |
| in_ready | output | 1 | A word can be accepted |
| out_ready | output | 1 | The output word is valid |

## Verification
The assertions check the properties that hold cycle by cycle:
- The occupancy never grows past full and never leaves zero without a capture.
- Both flags stay low in the full and empty states.
- The output holds its value while the buffer is empty.
- The reset state is correct.

Other behaviours only show up as sequences of strobes, so only the bench scenarios can demonstrate them. These are the order of words across a full fill and drain, the single-cycle flag pulses for automatic transfers, and capture when reset is released with shift-in held high.

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_in,
  input  logic             shift_out,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             in_ready,
  output logic             out_ready
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;
  logic [1:0]       si_sync, so_sync;
  logic             si_s, so_s;
  logic             taken, armed, ov;
  logic             full, push, pop, load;

  assign si_s = si_sync[1];
  assign so_s = so_sync[1];
  assign full = (cnt == CW'(DEPTH));
  assign push = si_s && !taken && !full;
  assign pop  = !so_s && armed;
  assign load = !ov && (cnt != '0) && !(cnt == CW'(1) && si_s);

  assign in_ready  = !full && !taken;
  assign out_ready = ov && !armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      si_sync <= '0;
      so_sync <= '0;
    end else begin
      si_sync <= {si_sync[0], shift_in};
      so_sync <= {so_sync[0], shift_out};
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      taken  <= 1'b0;
      armed  <= 1'b0;
      ov     <= 1'b0;
      dout   <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
      if (!si_s) taken <= 1'b0;
      else if (push) taken <= 1'b1;
      if (pop) begin
        armed <= 1'b0;
        ov    <= 1'b0;
      end else if (load) begin
        ov     <= 1'b1;
        dout   <= mem[rd_ptr];
        rd_ptr <= rd_ptr + 1'b1;
      end else if (so_s && ov) begin
        armed <= 1'b1;
      end
    end
  end

  a_r2_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
  a_r3_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !push) |=> (cnt == '0));
  a_r4_ir_low_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !in_ready);
  a_r5_or_low_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> !out_ready);
  a_r8_hold_dout: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |=> $stable(dout));
  a_r9_reset_state: assert property (@(posedge clk)
    !rst_n |-> (dout == '0 && in_ready && !out_ready));
endmodule

// File: tb/strobe_fifo_tb_top.sv
module strobe_fifo_tb_top;
  localparam int DEPTH = 64;
  localparam int WIDTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_in = 1'b0;
  logic shift_out = 1'b0;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] dout;
  logic in_ready, out_ready;

  int checks = 0;
  int errors = 0;
  int q[$];
  int last_word = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  strobe_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .shift_in(shift_in), .shift_out(shift_out),
    .din(din), .dout(dout), .in_ready(in_ready), .out_ready(out_ready));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_dout();
    return (q.size() > 0) ? q[0] : last_word;
  endfunction

  function automatic bit exp_in_ready();
    return q.size() < DEPTH;
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int w);
    din = WIDTH'(w);
    shift_in = 1'b1;
    wait_n(5);
    shift_in = 1'b0;
    wait_n(5);
    if (q.size() < DEPTH) q.push_back(w);
  endtask

  task automatic pop();
    shift_out = 1'b1;
    wait_n(5);
    shift_out = 1'b0;
    wait_n(5);
    if (q.size() > 0) last_word = q.pop_front();
  endtask

  task automatic check_state(input string tag);
    check(dout == WIDTH'(exp_dout()), {tag, " dout"}, dout, exp_dout());
    check(out_ready == (q.size() > 0), {tag, " out_ready"}, out_ready, q.size() > 0);
    check(in_ready == exp_in_ready(), {tag, " in_ready"}, in_ready, exp_in_ready());
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_n(3);
    check(dout == '0 && in_ready && !out_ready, "R9 reset state", {dout, in_ready, out_ready}, 2);
    rst_n = 1'b1;
    wait_n(3);
    q.delete();
    last_word = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    check_state("R9 after reset");

    for (int i = 0; i < 200; i++) begin
      if ($urandom_range(0, 1) == 1) push($urandom_range(0, 15));
      else pop();
      check_state("R1 R2 R3 random");
    end

    do_reset();
    for (int i = 0; i < DEPTH; i++) push((i * 7 + 3) % 16);
    check(!in_ready, "R4 full in_ready", in_ready, 0);
    push(9);
    check_state("R2 ignored when full");
    for (int i = 0; i < DEPTH; i++) begin
      check(dout == WIDTH'((i * 7 + 3) % 16), "R1 order", dout, (i * 7 + 3) % 16);
      pop();
    end
    check_state("R8 hold after drain");
    pop();
    check_state("R3 R8 pop when empty");

    begin
      int pulses = 0;
      shift_out = 1'b1;
      wait_n(5);
      din = 4'hA;
      shift_in = 1'b1;
      wait_n(5);
      shift_in = 1'b0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (out_ready) pulses++;
      end
      check(pulses == 1, "R6 out_ready pulse", pulses, 1);
      check(dout == 4'hA, "R6 fall-through data", dout, 10);
      shift_out = 1'b0;
      wait_n(6);
      last_word = 10;
      check_state("R6 removed on fall");
    end

    begin
      int pulses = 0;
      for (int i = 0; i < DEPTH; i++) push(i % 16);
      din = 4'h5;
      shift_in = 1'b1;
      wait_n(6);
      check(!in_ready, "R7 held while full", in_ready, 0);
      shift_out = 1'b1;
      wait_n(5);
      shift_out = 1'b0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (in_ready) pulses++;
      end
      check(pulses == 1, "R7 in_ready pulse", pulses, 1);
      shift_in = 1'b0;
      wait_n(5);
      last_word = q.pop_front();
      q.push_back(5);
      check_state("R7 auto capture");
      for (int i = 0; i < DEPTH; i++) pop();
      check(dout == 4'h5, "R7 captured word last", dout, 5);
    end

    din = 4'h6;
    shift_in = 1'b1;
    rst_n = 1'b0;
    wait_n(3);
    check(dout == '0, "R9 dout cleared", dout, 0);
    rst_n = 1'b1;
    wait_n(8);
    check(!in_ready, "R9 in_ready low until shift-in falls", in_ready, 0);
    shift_in = 1'b0;
    wait_n(5);
    q.delete();
    q.push_back(6);
    last_word = 0;
    check_state("R9 capture on release");

    shift_in = 1'b1;
    rst_n = 1'b0;
    wait_n(3);
    shift_in = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(6);
    q.delete();
    last_word = 0;
    check_state("R9 no capture");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule